// File: doc/BRIEF.md
# Hub Power-On Boot Sequencer

This block walks a USB hub controller from power-up to operation. While the active-low reset is held, the block stays in a standby stage with everything switched off. After reset is released it brings up the core regulator and the PLL. It captures the two configuration strap pins once the clock source is confirmed. It then decides how the configuration is loaded: from an external serial ROM, from a host on the management bus, or from the built-in defaults alone.

Host presence is sensed by enabling weak pull-downs on the bus data and clock lines. After a settle period the block checks whether external pull-ups hold both lines high. A host-configuration stage has no time limit and ends only when the host writes the terminator register address. Once configuration is done, a single merge pulse tells the settings store to combine its sources. The block then idles, and suspends until VBUS or a connect request appears. When VBUS appears, the block moves to charger detection or straight to connect.

The regulator, PLL, serial engines and charger detector are outside this block. They appear only as handshake inputs and outputs.

Top module: `hub_boot_seq`

## Requirements
- R1: While `rst_n` is low, `stage` is 0 (standby), `vreg_en` and `pll_en` are 0, and `mgmt_busy` is 1.
- R2: The first clock after `rst_n` rises enters `stage` 1 (hardware init) with `vreg_en` at 1. `pll_en` rises once `vreg_good` is seen. The block leaves stage 1 only when `vreg_good`, `pll_locked` and `refclk_ok` are all high. On that exit the straps are captured and `strap_latch` pulses for exactly one cycle. Strap changes made afterwards have no effect on the boot path.
- R3: While `refclk_ok` is low, the block stays in stage 1 regardless of the other ready inputs.
- R4: `mgmt_busy` is 1 in stages 0 and 1 and 0 in every later stage.
- R5: If the captured strap equals 2'b11, software init (`stage` 2) lasts one cycle and leads to `stage` 4 (configuration). In that stage `rom_req` is held at 1 until `rom_done` is seen, and the block does not leave stage 4 before then.
- R6: For any other strap value, stage 2 lasts exactly SETTLE cycles with `pd_en` at 1 throughout. At the end, the two-flop-synchronized `sda_in` and `scl_in` are both high → `stage` 3 (host configuration); otherwise → `stage` 4.
- R7: Stage 3 has no timeout. Only a cycle with `mgmt_wr` at 1 and `mgmt_addr` equal to 8'hFF moves it to stage 4. Other addresses, and the address alone without the strobe, leave it in stage 3.
- R8: Stage 4 ends with exactly one one-cycle `merge_pulse` per boot, high in the first cycle of `stage` 5 (idle).
- R9: In stage 5, `suspend` is 1 exactly when `vbus_on` and `connect_req` are both 0.
- R10: In stage 5 with `vbus_on` at 1, the next stage is 6 (charger detection) if `chg_en` is 1 and 7 (connect) if it is 0. Stages 6 and 7 hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; low means standby |
| refclk_ok | input | 1 | Reference clock present |
| vreg_good | input | 1 | Core regulator output in range |
| pll_locked | input | 1 | PLL lock indication |
| strap_sel | input | 2 | Configuration strap pins |
| sda_in | input | 1 | Raw level of bus data line |
| scl_in | input | 1 | Raw level of bus clock line |
| mgmt_wr | input | 1 | Management-slave register write strobe |
| mgmt_addr | input | 8 | Management-slave register address |
| rom_done | input | 1 | External ROM load complete |
| vbus_on | input | 1 | Upstream VBUS present |
| connect_req | input | 1 | Hub connect request |
| chg_en | input | 1 | Upstream battery charging detection enabled |
| stage | output | 3 | Current stage code (0..7) |
| vreg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | PLL enable |
| strap_latch | output | 1 | One-cycle pulse when straps are captured |
| mgmt_busy | output | 1 | Management interface not ready |
| pd_en | output | 1 | Weak pull-down enable on bus lines |
| rom_req | output | 1 | Request to load configuration from external ROM |
| merge_pulse | output | 1 | One-cycle configuration merge command |
| suspend | output | 1 | Idle with no VBUS and no connect request |

## Verification
The assertions assume the handshake inputs are level signals that stay stable for a whole clock. They also assume the bus line levels are steady during bus sensing, so the two-flop synchronizer delivers them before the settle count expires. The bench drives every input at the falling edge. It holds `sda_in` and `scl_in` fixed from before reset release, and raises `rom_done` only while the block is in the configuration stage. A full sweep covers every strap value, every pull-up combination and both charging-enable settings.

// File: rtl/hub_boot_seq.sv
module hub_boot_seq #(
  parameter int unsigned SETTLE    = 16,
  parameter logic [1:0]  ROM_STRAP = 2'b11,
  parameter logic [7:0]  TERM_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refclk_ok,
  input  logic       vreg_good,
  input  logic       pll_locked,
  input  logic [1:0] strap_sel,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       mgmt_wr,
  input  logic [7:0] mgmt_addr,
  input  logic       rom_done,
  input  logic       vbus_on,
  input  logic       connect_req,
  input  logic       chg_en,
  output logic [2:0] stage,
  output logic       vreg_en,
  output logic       pll_en,
  output logic       strap_latch,
  output logic       mgmt_busy,
  output logic       pd_en,
  output logic       rom_req,
  output logic       merge_pulse,
  output logic       suspend
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  typedef enum logic [2:0] {
    S_STBY = 3'd0, S_HW = 3'd1, S_SW = 3'd2, S_HOST = 3'd3,
    S_CFG = 3'd4, S_IDLE = 3'd5, S_CHG = 3'd6, S_CONN = 3'd7
  } st_t;

  st_t           st, nxt;
  logic [1:0]    strap_q;
  logic          pll_on, latch_q, merge_q;
  logic [CW-1:0] cnt;
  logic [1:0]    sda_s, scl_s;

  wire hw_ready = vreg_good && pll_locked && refclk_ok;
  wire rom_mode = strap_q == ROM_STRAP;
  wire settled  = cnt == LAST;
  wire bus_seen = sda_s[1] && scl_s[1];
  wire term_wr  = mgmt_wr && (mgmt_addr == TERM_ADDR);
  wire cfg_done = (st == S_CFG) && (!rom_mode || rom_done);

  always_comb begin
    nxt = st;
    case (st)
      S_STBY: nxt = S_HW;
      S_HW:   if (hw_ready) nxt = S_SW;
      S_SW:   if (rom_mode) nxt = S_CFG;
              else if (settled) nxt = bus_seen ? S_HOST : S_CFG;
      S_HOST: if (term_wr) nxt = S_CFG;
      S_CFG:  if (cfg_done) nxt = S_IDLE;
      S_IDLE: if (vbus_on) nxt = chg_en ? S_CHG : S_CONN;
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_STBY;
      strap_q <= '0;
      pll_on  <= 1'b0;
      latch_q <= 1'b0;
      merge_q <= 1'b0;
      cnt     <= '0;
      sda_s   <= '0;
      scl_s   <= '0;
    end else begin
      st      <= nxt;
      sda_s   <= {sda_s[0], sda_in};
      scl_s   <= {scl_s[0], scl_in};
      latch_q <= (st == S_HW) && hw_ready;
      merge_q <= cfg_done;
      if (st == S_HW && vreg_good) pll_on <= 1'b1;
      if (st == S_HW && hw_ready) strap_q <= strap_sel;
      if (st == S_SW && !rom_mode) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign stage       = st;
  assign vreg_en     = st != S_STBY;
  assign pll_en      = pll_on;
  assign strap_latch = latch_q;
  assign mgmt_busy   = (st == S_STBY) || (st == S_HW);
  assign pd_en       = (st == S_SW) && !rom_mode;
  assign rom_req     = (st == S_CFG) && rom_mode && !rom_done;
  assign merge_pulse = merge_q;
  assign suspend     = (st == S_IDLE) && !vbus_on && !connect_req;
endmodule

// File: rtl/hub_boot_seq_chk.sv
module hub_boot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       refclk_ok,
  input logic       mgmt_wr,
  input logic [7:0] mgmt_addr,
  input logic       vbus_on,
  input logic       chg_en,
  input logic [2:0] stage,
  input logic       vreg_en,
  input logic       pll_en,
  input logic       pd_en,
  input logic       rom_req,
  input logic       merge_pulse
);
  always @(posedge clk)
    if (!rst_n) AST_STANDBY_OFF: assert (stage == 3'd0 && !vreg_en && !pll_en); // R1

  AST_HOLD_NO_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd1 && !refclk_ok) |=> stage == 3'd1); // R3

  AST_PULLDOWN_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> stage == 3'd2); // R6

  AST_ROMREQ_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> stage == 3'd4); // R5

  AST_HOST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd3 && !(mgmt_wr && mgmt_addr == 8'hFF)) |=> stage == 3'd3); // R7

  AST_HOST_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd3 && mgmt_wr && mgmt_addr == 8'hFF) |=> stage == 3'd4); // R7

  AST_MERGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_pulse |=> !merge_pulse); // R8

  AST_MERGE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_pulse |-> stage == 3'd5); // R8

  AST_VBUS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd5 && vbus_on) |=> stage == (chg_en ? 3'd6 : 3'd7)); // R10
endmodule

bind hub_boot_seq hub_boot_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .mgmt_wr(mgmt_wr),
  .mgmt_addr(mgmt_addr), .vbus_on(vbus_on), .chg_en(chg_en), .stage(stage),
  .vreg_en(vreg_en), .pll_en(pll_en), .pd_en(pd_en), .rom_req(rom_req),
  .merge_pulse(merge_pulse)
);

// File: tb/hub_boot_seq_tb_top.sv
module hub_boot_seq_tb_top;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, refclk_ok = 1'b0, vreg_good = 1'b0, pll_locked = 1'b0;
  logic [1:0] strap_sel = 2'b00;
  logic       sda_in = 1'b0, scl_in = 1'b0, mgmt_wr = 1'b0;
  logic [7:0] mgmt_addr = 8'h00;
  logic       rom_done = 1'b0, vbus_on = 1'b0, connect_req = 1'b0, chg_en = 1'b0;
  logic [2:0] stage;
  logic       vreg_en, pll_en, strap_latch, mgmt_busy, pd_en, rom_req, merge_pulse, suspend;

  hub_boot_seq #(.SETTLE(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .vreg_good(vreg_good),
    .pll_locked(pll_locked), .strap_sel(strap_sel), .sda_in(sda_in), .scl_in(scl_in),
    .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .rom_done(rom_done), .vbus_on(vbus_on),
    .connect_req(connect_req), .chg_en(chg_en), .stage(stage), .vreg_en(vreg_en),
    .pll_en(pll_en), .strap_latch(strap_latch), .mgmt_busy(mgmt_busy), .pd_en(pd_en),
    .rom_req(rom_req), .merge_pulse(merge_pulse), .suspend(suspend)
  );

  int n_chk = 0, n_err = 0, merges = 0, latches = 0;

  always @(posedge clk) begin
    if (merge_pulse) merges++;
    if (strap_latch) latches++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic s);
    mgmt_addr = a; mgmt_wr = s;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] sv, input logic sd, input logic sc, input logic ce);
    bit rom, det;
    int ml, ll, n;
    rom = (sv == 2'b11);
    det = !rom && sd && sc;
    @(negedge clk);
    rst_n = 1'b0; refclk_ok = 1'b0; vreg_good = 1'b0; pll_locked = 1'b0;
    strap_sel = sv; sda_in = sd; scl_in = sc; mgmt_wr = 1'b0; mgmt_addr = 8'h00;
    rom_done = 1'b0; vbus_on = 1'b0; connect_req = 1'b0; chg_en = ce;
    repeat (2) @(negedge clk);
    check("R1 stage", stage, 0);
    check("R1 vreg_en", vreg_en, 0);
    check("R1 pll_en", pll_en, 0);
    check("R1 busy", mgmt_busy, 1);
    ml = merges; ll = latches;
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 stage hw", stage, 1);
    check("R2 vreg_en", vreg_en, 1);
    check("R2 pll_en before good", pll_en, 0);
    check("R4 busy hw", mgmt_busy, 1);
    vreg_good = 1'b1; pll_locked = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 no refclk", stage, 1);
    check("R2 pll_en", pll_en, 1);
    refclk_ok = 1'b1; pll_locked = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 wait lock", stage, 1);
    pll_locked = 1'b1;
    @(negedge clk);
    check("R2 enter sw", stage, 2);
    check("R4 busy sw", mgmt_busy, 0);
    strap_sel = ~sv;
    if (rom) begin
      check("R5 no pulldown", pd_en, 0);
      @(negedge clk);
      check("R5 rom cfg", stage, 4);
      check("R5 rom_req", rom_req, 1);
      repeat (3) @(negedge clk);
      check("R5 wait rom", stage, 4);
      check("R5 rom_req held", rom_req, 1);
      check("R8 no early merge", merges - ml, 0);
      rom_done = 1'b1;
      @(negedge clk);
      rom_done = 1'b0;
    end else begin
      check("R6 pulldown", pd_en, 1);
      n = 1;
      while (n < 100) begin
        @(negedge clk);
        if (stage == 3'd2) n++; else break;
      end
      check("R6 settle len", n, SETTLE);
      check("R6 detect", stage, det ? 3 : 4);
      if (det) begin
        check("R4 busy host", mgmt_busy, 0);
        wr(8'h10, 1'b1);
        check("R7 other addr", stage, 3);
        wr(8'hFE, 1'b1);
        check("R7 addr FE", stage, 3);
        wr(8'hFF, 1'b0);
        check("R7 no strobe", stage, 3);
        repeat (20) @(negedge clk);
        check("R7 no timeout", stage, 3);
        wr(8'hFF, 1'b1);
        check("R7 term", stage, 4);
      end
      @(negedge clk);
    end
    check("R8 idle", stage, 5);
    check("R8 merge high", merge_pulse, 1);
    @(negedge clk);
    check("R8 merge once", merges - ml, 1);
    check("R2 latch once", latches - ll, 1);
    check("R9 suspend", suspend, 1);
    connect_req = 1'b1;
    @(negedge clk);
    check("R9 connect no suspend", suspend, 0);
    check("R9 stay idle", stage, 5);
    connect_req = 1'b0;
    vbus_on = 1'b1;
    @(negedge clk);
    check("R10 branch", stage, ce ? 6 : 7);
    repeat (2) @(negedge clk);
    check("R10 hold", stage, ce ? 6 : 7);
    check("R9 no suspend", suspend, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 2; e++)
            run_one(2'(s), 1'(d), 1'(c), 1'(e));
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule